// File: doc/BRIEF.md
# Serially Configured Clock Fan-Out Gate

This block takes one reference clock and passes it to a bank of twelve output pairs plus one feedback output. Each pair has a "true" leg and a second leg. The second leg is normally the inverse of the true leg. Whether each pair and the feedback output may run is decided by enable bits. A host writes these bits over a two-wire SMBus block write. The block only receives: it has no read path.

The SMBus side runs in the system clock domain. Both bus lines are first synchronized. The block then finds START and STOP conditions and shifts bytes in, most significant bit first. It acknowledges its own address and every byte that follows. A write is laid out as the address byte, a command byte, a byte count, and then the data bytes. The data bytes are numbered from zero, in the order they arrive.

The clock side has no register between the reference clock and the outputs. Each enable passes through a level-sensitive latch. The latch is open only in the half period in which the output it controls sits low, so a change of enable never cuts a pulse short. An active-low power-down input forces every output low at once. A mode input sets the polarity of the second leg. When it is 1, all pairs are true/inverse. When it is 0, the six lowest pairs drive two in-phase copies, while the other six stay true/inverse.

Top module: `clk_fanout_ctrl`

## Requirements
- R1: The block answers only to the address byte {7'b1101001, write=0}. It pulls `sda_oe` high during the ninth clock of that byte. Any other address, including the same address with the read bit set, gets no acknowledge, and the data that follows changes no enable.
- R2: After the address come the command byte (its value is ignored) and then the count byte. Data byte k (k counted from 0) is written to configuration byte k. Bits arrive most significant first.
- R3: Bit p of configuration byte 7 enables pair p, for p from 0 to 7. A value of 1 means running.
- R4: Bits 3..0 of configuration byte 6 enable pairs 11..8, so bit 0 enables pair 8. Bit 4 enables `fb_out`. Bits 7..5 are reserved: they are stored as 0 and have no effect on any output.
- R5: After reset, configuration byte 7 is 8'hFF and byte 6 is 8'h1F, so every output is enabled.
- R6: While `pwr_dn_n` is 0, every bit of `out_t` and `out_c`, and `fb_out`, is 0, whatever the enables are.
- R7: A disabled pair holds both of its legs at 0. A disabled feedback output holds 0.
- R8: With `mode_dual`=1, an enabled pair drives `out_t`=`ref_clk` and `out_c`=~`ref_clk`. An enabled `fb_out` equals `ref_clk`.
- R9: With `mode_dual`=0, pairs 0..5 drive `out_c`=`out_t`=`ref_clk`, and pairs 6..11 stay true/inverse.
- R10: A new enable value reaches a true leg only while `ref_clk` is low. A pulse of `out_t` that is already high is never cut short.
- R11: Data bytes at a position at or beyond the count, or at position 8 or higher, are still acknowledged, but they are discarded.
- R12: A STOP or a repeated START in the middle of a byte throws the partial byte away and writes nothing.
- R13: `sda_oe` changes only while SCL is low. It rises after the falling edge of SCL that ends the eighth bit, and it falls after the falling edge that ends the ninth clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the serial receiver and the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SMBus clock line as seen at the pin |
| sda_i | input | 1 | SMBus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| ref_clk | input | 1 | Reference clock to be distributed |
| pwr_dn_n | input | 1 | Active-low power-down: forces all outputs low |
| mode_dual | input | 1 | 1: every pair is true/inverse; 0: pairs 0..5 are in-phase |
| out_t | output | 12 | True leg of each pair |
| out_c | output | 12 | Second leg of each pair (inverse or in-phase) |
| fb_out | output | 1 | Feedback copy of the reference clock |

## Verification
The bench sends a byte 7 value whose bit order reversed is a different value. A receiver that shifted the bits in the wrong direction would therefore enable the wrong pairs. It sets the reserved bits of byte 6, gives counts shorter than the data that follows, and aborts a byte midway with both a STOP and a repeated START. A receiver that kept partial bytes or ignored the count would change enables that must stay put.

It also holds the reference clock high while it disables a running pair. A gate that was not latched would drop `out_t` in the middle of the pulse. It runs both polarity modes with power-down toggling. A swapped range of in-phase pairs, or a power-down that only gated some outputs, would show up as a wrong output vector.

// File: rtl/clkfo_pkg.sv
`timescale 1ns/1ps
package clkfo_pkg;
   localparam int MAX_PAIRS   = 12;
   localparam int LO_BYTE_IDX = 6;
   localparam int HI_BYTE_IDX = 7;
   localparam int NUM_CFG     = 8;
   localparam int LO_USED     = 5;
   localparam logic [7:0] HI_RST = 8'hFF;
   localparam logic [LO_USED-1:0] LO_RST = 5'h1F;

   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_CNT  = 2'd1,
      PH_DATA = 2'd2
   } xfer_ph_e;
endpackage

// File: rtl/clkfo_sync.sv
`timescale 1ns/1ps
module clkfo_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("clkfo_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/clkfo_smb_rx.sv
`timescale 1ns/1ps
module clkfo_smb_rx #(
   parameter logic [6:0] DEV_ADDR   = 7'b1101001,
   parameter int          SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   output logic       byte_stb,
   output logic [7:0] byte_data,
   output logic       xfer_rst
);
   localparam logic [7:0] ADDR_WR = {DEV_ADDR, 1'b0};
   localparam int         BITS    = 8;

   logic scl_s, sda_s, scl_q, sda_q;
   logic active, addr_ph, ack_ph;
   logic [3:0] bitcnt;
   logic [BITS-1:0] shreg;

   clkfo_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
   clkfo_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   wire start_det = scl_s & scl_q &  sda_q & ~sda_s;
   wire stop_det  = scl_s & scl_q & ~sda_q &  sda_s;
   wire scl_rise  =  scl_s & ~scl_q;
   wire scl_fall  = ~scl_s &  scl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
         active   <= 1'b0;
         addr_ph  <= 1'b0;
         ack_ph   <= 1'b0;
         bitcnt   <= '0;
         shreg    <= '0;
         sda_oe   <= 1'b0;
         byte_stb <= 1'b0;
      end else begin
         scl_q    <= scl_s;
         sda_q    <= sda_s;
         byte_stb <= 1'b0;
         if (start_det || stop_det) begin
            active  <= start_det;
            addr_ph <= 1'b1;
            ack_ph  <= 1'b0;
            bitcnt  <= '0;
            sda_oe  <= 1'b0;
         end else if (active) begin
            if (scl_rise && bitcnt < 4'(BITS)) begin
               shreg  <= {shreg[BITS-2:0], sda_s};
               bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && ack_ph) begin
               ack_ph <= 1'b0;
               sda_oe <= 1'b0;
               bitcnt <= '0;
            end else if (scl_fall && bitcnt == 4'(BITS)) begin
               if (addr_ph) begin
                  if (shreg == ADDR_WR) begin
                     ack_ph  <= 1'b1;
                     sda_oe  <= 1'b1;
                     addr_ph <= 1'b0;
                  end else begin
                     active  <= 1'b0;
                  end
               end else begin
                  ack_ph   <= 1'b1;
                  sda_oe   <= 1'b1;
                  byte_stb <= 1'b1;
               end
            end
         end
      end
   end

   assign byte_data = shreg;
   assign xfer_rst  = start_det | stop_det;
endmodule

// File: rtl/clkfo_cfg_regs.sv
`timescale 1ns/1ps
module clkfo_cfg_regs
   import clkfo_pkg::*;
#(
   parameter int NPAIR = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_stb,
   input  logic [7:0]       byte_data,
   input  logic             xfer_rst,
   output logic [NPAIR-1:0] pair_en,
   output logic             fb_en
);
   localparam int HI_PAIRS = 8;
   localparam int FB_BIT   = 4;

   xfer_ph_e         phase;
   logic [7:0]       count_q;
   logic [3:0]       didx;
   logic [7:0]       hi_q;
   logic [LO_USED-1:0] lo_q;

   wire keep = ({4'd0, didx} < count_q) && (didx < 4'(NUM_CFG));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_CMD;
         count_q <= '0;
         didx    <= '0;
         hi_q    <= HI_RST;
         lo_q    <= LO_RST;
      end else if (xfer_rst) begin
         phase <= PH_CMD;
         didx  <= '0;
      end else if (byte_stb) begin
         unique case (phase)
            PH_CMD: phase <= PH_CNT;
            PH_CNT: begin
               count_q <= byte_data;
               phase   <= PH_DATA;
            end
            default: begin
               if (keep && didx == 4'(HI_BYTE_IDX)) hi_q <= byte_data;
               if (keep && didx == 4'(LO_BYTE_IDX)) lo_q <= byte_data[LO_USED-1:0];
               if (didx < 4'(NUM_CFG)) didx <= didx + 4'd1;
            end
         endcase
      end
   end

   for (genvar p = 0; p < NPAIR; p++) begin : g_map
      if (p < HI_PAIRS) begin : g_hi
         assign pair_en[p] = hi_q[p];
      end else begin : g_lo
         assign pair_en[p] = lo_q[p-HI_PAIRS];
      end
   end
   assign fb_en = lo_q[FB_BIT];
endmodule

// File: rtl/clkfo_gate.sv
`timescale 1ns/1ps
module clkfo_gate #(
   parameter int NPAIR     = 12,
   parameter int N_INPHASE = 6
) (
   input  logic             ref_clk,
   input  logic             pwr_dn_n,
   input  logic             mode_dual,
   input  logic [NPAIR-1:0] pair_en,
   input  logic             fb_en,
   output logic [NPAIR-1:0] out_t,
   output logic [NPAIR-1:0] out_c,
   output logic             fb_out
);
   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      logic en_lo, en_hi;
      always_latch if (!ref_clk) en_lo <= pair_en[p];
      always_latch if (ref_clk)  en_hi <= pair_en[p];

      assign out_t[p] = pwr_dn_n & en_lo & ref_clk;
      if (p < N_INPHASE) begin : g_sel
         assign out_c[p] = pwr_dn_n &
                           (mode_dual ? (en_hi & ~ref_clk) : (en_lo & ref_clk));
      end else begin : g_inv
         assign out_c[p] = pwr_dn_n & en_hi & ~ref_clk;
      end
   end

   logic fb_lat;
   always_latch if (!ref_clk) fb_lat <= fb_en;
   assign fb_out = pwr_dn_n & fb_lat & ref_clk;
endmodule

// File: rtl/clk_fanout_ctrl.sv
`timescale 1ns/1ps
module clk_fanout_ctrl
   import clkfo_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'b1101001,
   parameter int         NPAIR       = 12,
   parameter int         N_INPHASE   = 6,
   parameter int         SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   input  logic             ref_clk,
   input  logic             pwr_dn_n,
   input  logic             mode_dual,
   output logic [NPAIR-1:0] out_t,
   output logic [NPAIR-1:0] out_c,
   output logic             fb_out
);
   if (NPAIR < 1 || NPAIR > MAX_PAIRS) begin : g_bad_npair
      $error("clk_fanout_ctrl: NPAIR out of range");
   end
   if (N_INPHASE < 0 || N_INPHASE > NPAIR) begin : g_bad_inphase
      $error("clk_fanout_ctrl: N_INPHASE out of range");
   end

   logic             byte_stb, xfer_rst, fb_en;
   logic [7:0]       byte_data;
   logic [NPAIR-1:0] pair_en;

   clkfo_smb_rx #(.DEV_ADDR(DEV_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_oe(sda_oe), .byte_stb(byte_stb), .byte_data(byte_data),
      .xfer_rst(xfer_rst));

   clkfo_cfg_regs #(.NPAIR(NPAIR)) u_cfg (
      .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_data(byte_data),
      .xfer_rst(xfer_rst), .pair_en(pair_en), .fb_en(fb_en));

   clkfo_gate #(.NPAIR(NPAIR), .N_INPHASE(N_INPHASE)) u_gate (
      .ref_clk(ref_clk), .pwr_dn_n(pwr_dn_n), .mode_dual(mode_dual),
      .pair_en(pair_en), .fb_en(fb_en), .out_t(out_t), .out_c(out_c),
      .fb_out(fb_out));
endmodule

// File: rtl/clkfo_checker.sv
`timescale 1ns/1ps
module clkfo_checker #(
   parameter int NPAIR     = 12,
   parameter int N_INPHASE = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_i,
   input logic             sda_oe,
   input logic             ref_clk,
   input logic             pwr_dn_n,
   input logic             mode_dual,
   input logic [NPAIR-1:0] out_t,
   input logic [NPAIR-1:0] out_c,
   input logic             fb_out
);
   a_r6_pdn_all_low: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_dn_n |-> (out_t == '0 && out_c == '0 && !fb_out));

   a_r8_true_only_when_ref_high: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_clk |-> (out_t == '0 && !fb_out));

   a_r8_pairs_never_both_high: assert property (@(posedge clk) disable iff (!rst_n)
      mode_dual |-> ((out_t & out_c) == '0));

   a_r9_inphase_match: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_dual |-> (out_c[N_INPHASE-1:0] == out_t[N_INPHASE-1:0]));

   a_r13_ack_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_i);
endmodule

bind clk_fanout_ctrl clkfo_checker #(.NPAIR(NPAIR), .N_INPHASE(N_INPHASE)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
   .ref_clk(ref_clk), .pwr_dn_n(pwr_dn_n), .mode_dual(mode_dual),
   .out_t(out_t), .out_c(out_c), .fb_out(fb_out));

// File: tb/clk_fanout_ctrl_tb.sv
`timescale 1ns/1ps
module clk_fanout_ctrl_tb_top;
   localparam int NP  = 12;
   localparam int NIP = 6;
   localparam int HB  = 8;
   localparam logic [7:0] ADDR_W = 8'b1101_0010;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda_drv = 1'b1;
   logic ref_clk = 1'b0, pwr_dn_n = 1'b1, mode_dual = 1'b1;
   logic sda_oe, fb_out;
   logic [NP-1:0] out_t, out_c;
   logic sda_line;

   assign sda_line = sda_drv & ~sda_oe;

   always #2 clk = ~clk;

   clk_fanout_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
      .ref_clk(ref_clk), .pwr_dn_n(pwr_dn_n), .mode_dual(mode_dual),
      .out_t(out_t), .out_c(out_c), .fb_out(fb_out));

   int n_tests = 0, n_fail = 0, rel_err = 0;
   logic [7:0] exp_hi = 8'hFF;
   logic [4:0] exp_lo = 5'h1F;
   logic [7:0] dbuf [0:15];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hb_wait();
      repeat (HB) @(negedge clk);
   endtask

   function automatic logic [2*NP:0] expect_out(input logic r);
      logic [NP-1:0] t, c;
      logic f, e;
      for (int p = 0; p < NP; p++) begin
         e = (p < 8) ? exp_hi[p] : exp_lo[p-8];
         e = e & pwr_dn_n;
         t[p] = e & r;
         c[p] = e & ((!mode_dual && p < NIP) ? r : ~r);
      end
      f = exp_lo[4] & pwr_dn_n & r;
      return {t, c, f};
   endfunction

   task automatic check_out(input string req);
      ref_clk = 1'b0; repeat (4) @(negedge clk);
      ref_clk = 1'b1; repeat (4) @(negedge clk);
      chk(req, 32'({out_t, out_c, fb_out}), 32'(expect_out(1'b1)));
      ref_clk = 1'b0; repeat (4) @(negedge clk);
      chk(req, 32'({out_t, out_c, fb_out}), 32'(expect_out(1'b0)));
   endtask

   task automatic smb_start();
      sda_drv = 1'b1; hb_wait();
      scl = 1'b1; hb_wait();
      sda_drv = 1'b0; hb_wait();
      scl = 1'b0; hb_wait();
   endtask

   task automatic smb_stop();
      sda_drv = 1'b0; hb_wait();
      scl = 1'b1; hb_wait();
      sda_drv = 1'b1; hb_wait();
   endtask

   task automatic smb_bit(input logic b);
      sda_drv = b; hb_wait();
      scl = 1'b1; hb_wait();
      scl = 1'b0; hb_wait();
   endtask

   task automatic smb_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) smb_bit(b[i]);
      sda_drv = 1'b1; hb_wait();
      scl = 1'b1; hb_wait();
      ack = sda_oe;
      scl = 1'b0; hb_wait();
      if (sda_oe) rel_err++;
   endtask

   task automatic smb_write(input logic [7:0] abyte, input logic [7:0] cnt,
                            input int n, output logic a_ack, output logic d_ack);
      logic k;
      d_ack = 1'b1;
      smb_start();
      smb_byte(abyte, a_ack);
      smb_byte(8'h00, k); d_ack &= k;
      smb_byte(cnt, k);   d_ack &= k;
      for (int i = 0; i < n; i++) begin
         smb_byte(dbuf[i], k); d_ack &= k;
      end
      smb_stop();
   endtask

   task automatic model_apply(input logic [7:0] cnt, input int n);
      for (int i = 0; i < n; i++) begin
         if (i < int'(cnt) && i < 8) begin
            if (i == 7) exp_hi = dbuf[i];
            if (i == 6) exp_lo = dbuf[i][4:0];
         end
      end
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic aa, da;
      void'($urandom(32'h5EED_1234));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R5: reset defaults enable everything
      check_out("R5 reset defaults");
      chk("R13 ack idle after reset", 32'(sda_oe), 32'd0);

      // R1: wrong address and read bit are not acknowledged, no effect
      for (int i = 0; i < 8; i++) dbuf[i] = 8'h00;
      smb_write(8'b1001_0110, 8'd8, 8, aa, da);
      chk("R1 foreign address no ack", 32'(aa), 32'd0);
      smb_write(ADDR_W | 8'h01, 8'd8, 8, aa, da);
      chk("R1 read bit no ack", 32'(aa), 32'd0);
      check_out("R1 foreign address no effect");

      // R2 R3 R4: msb-first load, reserved bits ignored
      dbuf[6] = 8'hE6; dbuf[7] = 8'hC9;
      smb_write(ADDR_W, 8'd8, 8, aa, da);
      chk("R1 own address acked", 32'(aa), 32'd1);
      chk("R13 data bytes acked", 32'(da), 32'd1);
      model_apply(8'd8, 8);
      check_out("R2 R3 R4 R7 map and order");

      // R11: count shorter than data, and data beyond index 7
      dbuf[6] = 8'h1F; dbuf[7] = 8'h00;
      smb_write(ADDR_W, 8'd7, 8, aa, da);
      chk("R11 extra bytes still acked", 32'(da), 32'd1);
      model_apply(8'd7, 8);
      check_out("R11 byte beyond count dropped");
      dbuf[7] = 8'hFF; dbuf[8] = 8'h00; dbuf[9] = 8'h00;
      smb_write(ADDR_W, 8'd10, 10, aa, da);
      chk("R11 index above 7 acked", 32'(da), 32'd1);
      model_apply(8'd10, 10);
      check_out("R11 index above 7 dropped");

      // R12: STOP mid-byte aborts
      smb_start();
      smb_byte(ADDR_W, aa); smb_byte(8'h00, aa); smb_byte(8'd8, aa);
      for (int i = 0; i < 7; i++) smb_byte(dbuf[i], aa);
      for (int i = 0; i < 4; i++) smb_bit(1'b0);
      smb_stop();
      check_out("R12 stop aborts partial byte");
      // R12: repeated START mid-byte aborts
      smb_start();
      smb_byte(ADDR_W, aa); smb_byte(8'h00, aa); smb_byte(8'd8, aa);
      for (int i = 0; i < 7; i++) smb_byte(dbuf[i], aa);
      for (int i = 0; i < 5; i++) smb_bit(1'b0);
      smb_start();
      smb_stop();
      check_out("R12 repeated start aborts partial byte");

      // R6: power-down
      pwr_dn_n = 1'b0;
      check_out("R6 power-down all low");
      pwr_dn_n = 1'b1;

      // R9: in-phase mode
      mode_dual = 1'b0;
      check_out("R9 in-phase lower pairs");
      mode_dual = 1'b1;
      check_out("R8 true/inverse all pairs");

      // R10: enable change while ref high does not cut pulse
      ref_clk = 1'b1; repeat (4) @(negedge clk);
      chk("R10 pair0 running before", 32'(out_t[0]), 32'd1);
      for (int i = 0; i < 8; i++) dbuf[i] = 8'h00;
      dbuf[6] = {3'b000, exp_lo};
      smb_write(ADDR_W, 8'd8, 8, aa, da);
      chk("R10 pulse held while ref high", 32'(out_t[0]), 32'd1);
      model_apply(8'd8, 8);
      ref_clk = 1'b0; repeat (4) @(negedge clk);
      ref_clk = 1'b1; repeat (4) @(negedge clk);
      chk("R10 disabled after low phase", 32'(out_t[0]), 32'd0);
      check_out("R7 disabled pairs low");

      // random mix
      for (int it = 0; it < 14; it++) begin
         logic [7:0] cnt;
         for (int i = 0; i < 9; i++) dbuf[i] = 8'($urandom);
         cnt = 8'(5 + ($urandom % 5));
         smb_write(ADDR_W, cnt, 9, aa, da);
         chk("R1 random ack", 32'({aa, da}), 32'h3);
         model_apply(cnt, 9);
         mode_dual = 1'($urandom);
         pwr_dn_n = (($urandom % 4) != 0);
         check_out("R3 R4 R6 R8 R9 random");
      end
      pwr_dn_n = 1'b1;

      chk("R13 ack released after ninth clock", 32'(rel_err), 32'd0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule